// File: doc/BRIEF.md
# Calendar Shadow Register Synchronizer

This block gives a bus-clocked reader a coherent view of a calendar (subsecond, time and date) that advances in a slow real-time clock domain. On a fixed cadence of real-time clock periods it captures the live calendar values into a holding register, and it signals the capture across to the bus domain. The bus side then loads its shadow registers from the stable holding register and raises a synchronized flag. Software can clear the flag and wait for it to rise again, so that it knows the shadow copy is fresh.

While the low-power indication is active, no capture is taken and the shadow copy stays frozen. When the indication drops, the next real-time clock edge takes a capture at once. A bypass control routes the live calendar inputs straight to the read outputs, for readers that cannot wait for a copy. Correct shadow operation assumes the bus clock runs at no less than seven times the real-time clock.

Top module: `cal_shadow_sync`

## Requirements
- R1: A capture of all three calendar fields is taken every CADENCE (default 2) real-time clock periods, all three from the same edge. The shadow copy changes only when a capture arrives, so with the live time advancing by one per period, consecutive shadow time values differ by exactly CADENCE.
- R2: Each capture that reaches the bus domain sets sync_flag_o to 1. The flag stays at 1 until it is cleared.
- R3: While lowpwr_i is 1, no capture is taken, the shadow values do not change and sync_flag_o is not set.
- R4: After lowpwr_i returns to 0, a capture is taken on the first real-time clock rising edge. Shadow values and sync_flag_o are updated within two real-time clock periods.
- R5: While bypass_i is 1, rd_ss_o, rd_time_o and rd_date_o equal live_ss_i, live_time_i and live_date_i in the same cycle.
- R6: While bypass_i is 0, the read outputs return the shadow copy, not the live inputs. Since bypass_i is 0 by default, shadow reads are the default.
- R7: A one-cycle pulse on sync_clr_i clears sync_flag_o in the next bus cycle. A capture arriving in the same cycle wins and leaves the flag set.
- R8: While rst_ni is low, the shadow registers read 0 and sync_flag_o is 0.
- R9: With the bus clock at no less than seven times the real-time clock, the shadow time never trails the live time by more than CADENCE+1 real-time clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rtc_clk_i | input | 1 | Slow real-time clock |
| bus_clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| live_ss_i | input | SS_W | Live subsecond value (real-time clock domain) |
| live_time_i | input | TIME_W | Live time value (real-time clock domain) |
| live_date_i | input | DATE_W | Live date value (real-time clock domain) |
| lowpwr_i | input | 1 | Low-power indication, suspends captures (real-time clock domain) |
| bypass_i | input | 1 | 1: read the live values; 0: read the shadow copy |
| sync_clr_i | input | 1 | Clears the synchronized flag (bus domain) |
| rd_ss_o | output | SS_W | Subsecond read data |
| rd_time_o | output | TIME_W | Time read data |
| rd_date_o | output | DATE_W | Date read data |
| sync_flag_o | output | 1 | Shadow registers synchronized flag |

## Verification
The bench builds the block with its defaults: a cadence of 2, two synchronizer stages, and field widths of 16, 24 and 24 bits. The real-time clock runs at one sixteenth of the bus clock. At that ratio every capture crosses the synchronizer well inside its cadence window. The step between shadow values, the worst lag behind the live count and the wake-up latency can then be checked with tight bounds. The live fields are derived from one counter, each in a different way, so a torn copy that mixes two captures shows up as a mismatch between fields.

// File: rtl/cal_shadow_pkg.sv
package cal_shadow_pkg;
  localparam int unsigned CAL_SS_W_DEF   = 16;
  localparam int unsigned CAL_TIME_W_DEF = 24;
  localparam int unsigned CAL_DATE_W_DEF = 24;
  localparam int unsigned CAL_CADENCE_DEF = 2;
  localparam int unsigned CAL_SYNC_DEF   = 2;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cal_copy_pacer.sv
module cal_copy_pacer
  import cal_shadow_pkg::*;
#(
  parameter int unsigned SS_W    = CAL_SS_W_DEF,
  parameter int unsigned TIME_W  = CAL_TIME_W_DEF,
  parameter int unsigned DATE_W  = CAL_DATE_W_DEF,
  parameter int unsigned CADENCE = CAL_CADENCE_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SS_W-1:0]   live_ss_i,
  input  logic [TIME_W-1:0] live_time_i,
  input  logic [DATE_W-1:0] live_date_i,
  input  logic              lowpwr_i,
  output logic [SS_W-1:0]   hold_ss_o,
  output logic [TIME_W-1:0] hold_time_o,
  output logic [DATE_W-1:0] hold_date_o,
  output logic              req_tgl_o
);
  localparam int unsigned CNT_W = cnt_width(CADENCE);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CADENCE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             fire;

  assign fire = !lowpwr_i && (cnt_q == LAST);

  // counter parks at LAST in low power so the first edge after wake captures
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LAST;
    end else if (lowpwr_i || fire) begin
      cnt_q <= lowpwr_i ? LAST : '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_ss_o   <= '0;
      hold_time_o <= '0;
      hold_date_o <= '0;
      req_tgl_o   <= 1'b0;
    end else if (fire) begin
      hold_ss_o   <= live_ss_i;
      hold_time_o <= live_time_i;
      hold_date_o <= live_date_i;
      req_tgl_o   <= ~req_tgl_o;
    end
  end
endmodule

// File: rtl/cal_toggle_sync.sv
module cal_toggle_sync
  import cal_shadow_pkg::*;
#(
  parameter int unsigned STAGES = CAL_SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= tgl_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign pulse_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/cal_shadow_bank.sv
module cal_shadow_bank
  import cal_shadow_pkg::*;
#(
  parameter int unsigned SS_W   = CAL_SS_W_DEF,
  parameter int unsigned TIME_W = CAL_TIME_W_DEF,
  parameter int unsigned DATE_W = CAL_DATE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SS_W-1:0]   hold_ss_i,
  input  logic [TIME_W-1:0] hold_time_i,
  input  logic [DATE_W-1:0] hold_date_i,
  input  logic [SS_W-1:0]   live_ss_i,
  input  logic [TIME_W-1:0] live_time_i,
  input  logic [DATE_W-1:0] live_date_i,
  input  logic              bypass_i,
  input  logic              clr_i,
  output logic [SS_W-1:0]   rd_ss_o,
  output logic [TIME_W-1:0] rd_time_o,
  output logic [DATE_W-1:0] rd_date_o,
  output logic              flag_o
);
  logic [SS_W-1:0]   sh_ss_q;
  logic [TIME_W-1:0] sh_time_q;
  logic [DATE_W-1:0] sh_date_q;

  // hold data is static for CADENCE slow periods when load_i fires
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_ss_q   <= '0;
      sh_time_q <= '0;
      sh_date_q <= '0;
    end else if (load_i) begin
      sh_ss_q   <= hold_ss_i;
      sh_time_q <= hold_time_i;
      sh_date_q <= hold_date_i;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (load_i) flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  always_comb begin
    if (bypass_i) begin
      rd_ss_o   = live_ss_i;
      rd_time_o = live_time_i;
      rd_date_o = live_date_i;
    end else begin
      rd_ss_o   = sh_ss_q;
      rd_time_o = sh_time_q;
      rd_date_o = sh_date_q;
    end
  end
endmodule

// File: rtl/cal_shadow_sync.sv
module cal_shadow_sync
  import cal_shadow_pkg::*;
#(
  parameter int unsigned SS_W        = CAL_SS_W_DEF,
  parameter int unsigned TIME_W      = CAL_TIME_W_DEF,
  parameter int unsigned DATE_W      = CAL_DATE_W_DEF,
  parameter int unsigned CADENCE     = CAL_CADENCE_DEF,
  parameter int unsigned SYNC_STAGES = CAL_SYNC_DEF
) (
  input  logic              rtc_clk_i,
  input  logic              bus_clk_i,
  input  logic              rst_ni,
  input  logic [SS_W-1:0]   live_ss_i,
  input  logic [TIME_W-1:0] live_time_i,
  input  logic [DATE_W-1:0] live_date_i,
  input  logic              lowpwr_i,
  input  logic              bypass_i,
  input  logic              sync_clr_i,
  output logic [SS_W-1:0]   rd_ss_o,
  output logic [TIME_W-1:0] rd_time_o,
  output logic [DATE_W-1:0] rd_date_o,
  output logic              sync_flag_o
);
  logic [SS_W-1:0]   hold_ss;
  logic [TIME_W-1:0] hold_time;
  logic [DATE_W-1:0] hold_date;
  logic              req_tgl;
  logic              copy_stb;

  cal_copy_pacer #(
    .SS_W(SS_W), .TIME_W(TIME_W), .DATE_W(DATE_W), .CADENCE(CADENCE)
  ) u_pacer (
    .clk_i      (rtc_clk_i),
    .rst_ni     (rst_ni),
    .live_ss_i  (live_ss_i),
    .live_time_i(live_time_i),
    .live_date_i(live_date_i),
    .lowpwr_i   (lowpwr_i),
    .hold_ss_o  (hold_ss),
    .hold_time_o(hold_time),
    .hold_date_o(hold_date),
    .req_tgl_o  (req_tgl)
  );

  cal_toggle_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i  (bus_clk_i),
    .rst_ni (rst_ni),
    .tgl_i  (req_tgl),
    .pulse_o(copy_stb)
  );

  cal_shadow_bank #(
    .SS_W(SS_W), .TIME_W(TIME_W), .DATE_W(DATE_W)
  ) u_bank (
    .clk_i      (bus_clk_i),
    .rst_ni     (rst_ni),
    .load_i     (copy_stb),
    .hold_ss_i  (hold_ss),
    .hold_time_i(hold_time),
    .hold_date_i(hold_date),
    .live_ss_i  (live_ss_i),
    .live_time_i(live_time_i),
    .live_date_i(live_date_i),
    .bypass_i   (bypass_i),
    .clr_i      (sync_clr_i),
    .rd_ss_o    (rd_ss_o),
    .rd_time_o  (rd_time_o),
    .rd_date_o  (rd_date_o),
    .flag_o     (sync_flag_o)
  );
endmodule

// File: rtl/cal_shadow_sync_chk.sv
module cal_shadow_sync_chk #(
  parameter int unsigned TIME_W = 24
) (
  input logic              rtc_clk_i,
  input logic              bus_clk_i,
  input logic              rst_ni,
  input logic              lowpwr_i,
  input logic              bypass_i,
  input logic              sync_clr_i,
  input logic              sync_flag_o,
  input logic [TIME_W-1:0] rd_time_o,
  input logic [TIME_W-1:0] hold_time,
  input logic              req_tgl,
  input logic              copy_stb
);
  p_shadow_load_r1: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (copy_stb && !bypass_i) |=> (bypass_i || rd_time_o == $past(hold_time)));

  p_shadow_keep_r1: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (!copy_stb && !bypass_i) |=> (bypass_i || $stable(rd_time_o)));

  p_flag_set_r2: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    copy_stb |=> sync_flag_o);

  p_flag_hold_r2: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (sync_flag_o && !sync_clr_i) |=> sync_flag_o);

  p_flag_clr_r7: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (sync_clr_i && !copy_stb) |=> !sync_flag_o);

  p_no_copy_lp_r3: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    lowpwr_i |=> $stable(req_tgl));

  p_wake_copy_r4: assert property (@(posedge rtc_clk_i) disable iff (!rst_ni)
    (!lowpwr_i && $past(lowpwr_i)) |=> (req_tgl != $past(req_tgl)));
endmodule

bind cal_shadow_sync cal_shadow_sync_chk #(.TIME_W(TIME_W)) u_chk (
  .rtc_clk_i  (rtc_clk_i),
  .bus_clk_i  (bus_clk_i),
  .rst_ni     (rst_ni),
  .lowpwr_i   (lowpwr_i),
  .bypass_i   (bypass_i),
  .sync_clr_i (sync_clr_i),
  .sync_flag_o(sync_flag_o),
  .rd_time_o  (rd_time_o),
  .hold_time  (hold_time),
  .req_tgl    (req_tgl),
  .copy_stb   (copy_stb)
);

// File: tb/cal_shadow_sync_tb_top.sv
`timescale 1ns/1ps
module cal_shadow_sync_tb_top;
  localparam int SS_W = 16, TIME_W = 24, DATE_W = 24;
  localparam int CADENCE = 2;

  logic rtc_clk = 1'b0, bus_clk = 1'b0, rst_n = 1'b0;
  logic lowpwr = 1'b0, bypass = 1'b0, clr = 1'b0;
  logic [23:0] cnt = 24'h000100;
  logic [SS_W-1:0]   rd_ss;
  logic [TIME_W-1:0] rd_time;
  logic [DATE_W-1:0] rd_date;
  logic              flag;
  int n_chk = 0, n_bad = 0;

  always #2.5 bus_clk = ~bus_clk;
  always #40  rtc_clk = ~rtc_clk;

  function automatic logic [SS_W-1:0] ss_of(input logic [23:0] v);
    return v[15:0] ^ 16'h5A5A;
  endfunction
  function automatic logic [DATE_W-1:0] date_of(input logic [23:0] v);
    return ~v;
  endfunction

  // live calendar advances on every slow falling edge
  initial forever begin
    @(negedge rtc_clk);
    cnt = cnt + 24'd1;
  end

  cal_shadow_sync dut_i (
    .rtc_clk_i  (rtc_clk),
    .bus_clk_i  (bus_clk),
    .rst_ni     (rst_n),
    .live_ss_i  (ss_of(cnt)),
    .live_time_i(cnt),
    .live_date_i(date_of(cnt)),
    .lowpwr_i   (lowpwr),
    .bypass_i   (bypass),
    .sync_clr_i (clr),
    .rd_ss_o    (rd_ss),
    .rd_time_o  (rd_time),
    .rd_date_o  (rd_date),
    .sync_flag_o(flag)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_rtc(input int n);
    for (int i = 0; i < n; i++) @(negedge rtc_clk);
    @(negedge bus_clk);
  endtask

  task automatic pulse_clr();
    @(negedge bus_clk);
    clr = 1'b1;
    @(negedge bus_clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    wait_rtc(3);
    check("R8", "flag in reset", flag, 0);
    check("R8", "shadow time in reset", rd_time, 0);
    check("R6", "default read is shadow not live", rd_date, 0);
    @(negedge rtc_clk);
    rst_n = 1'b1;
    wait_rtc(2);
    check("R2", "flag after first copy", flag, 1);
    check("R1", "ss coherent with time", rd_ss, ss_of(rd_time));
    check("R1", "date coherent with time", rd_date, date_of(rd_time));
  endtask

  task automatic t_cadence();
    logic [TIME_W-1:0] prev;
    int changes = 0, bad_step = 0, bad_coh = 0, max_lag = 0;
    prev = rd_time;
    for (int i = 0; i < 16 * 20; i++) begin
      @(negedge bus_clk);
      if (rd_time != prev) begin
        changes++;
        if (rd_time != prev + TIME_W'(CADENCE)) bad_step++;
        prev = rd_time;
      end
      if (rd_ss != ss_of(rd_time) || rd_date != date_of(rd_time)) bad_coh++;
      if (int'(cnt - rd_time) > max_lag) max_lag = int'(cnt - rd_time);
    end
    check("R1", "shadow step errors", bad_step, 0);
    check("R1", "torn copies", bad_coh, 0);
    check("R1", "copies in 20 slow periods", (changes >= 9 && changes <= 11), 1);
    check("R9", "max lag within CADENCE+1", (max_lag <= CADENCE + 1), 1);
  endtask

  task automatic t_flag();
    pulse_clr();
    wait_rtc(3);
    check("R2", "flag set again by new copy", flag, 1);
  endtask

  task automatic t_lowpower_bypass();
    logic [TIME_W-1:0] frozen;
    @(negedge rtc_clk);
    lowpwr = 1'b1;
    wait_rtc(2);
    frozen = rd_time;
    pulse_clr();
    @(negedge bus_clk);
    check("R7", "flag cleared by pulse", flag, 0);
    wait_rtc(8);
    check("R3", "flag stays clear in low power", flag, 0);
    check("R3", "shadow frozen in low power", rd_time, frozen);
    check("R3", "live moved on", (cnt != frozen), 1);
    bypass = 1'b1;
    #0.5;
    check("R5", "bypass time is live", rd_time, cnt);
    check("R5", "bypass ss is live", rd_ss, ss_of(cnt));
    check("R5", "bypass date is live", rd_date, date_of(cnt));
    @(negedge bus_clk);
    bypass = 1'b0;
    #0.5;
    check("R6", "bypass off returns shadow", rd_time, frozen);
  endtask

  task automatic t_wake();
    @(negedge rtc_clk);
    lowpwr = 1'b0;
    @(negedge rtc_clk);
    @(negedge rtc_clk);
    #2.5;
    check("R4", "flag within two slow periods of wake", flag, 1);
    check("R4", "shadow refreshed after wake", (int'(cnt - rd_time) <= CADENCE), 1);
  endtask

  task automatic t_clr_vs_copy();
    bit seen = 1'b0;
    // drive clear every bus cycle for four slow periods: copies still set the flag
    for (int i = 0; i < 64; i++) begin
      @(negedge bus_clk);
      clr = 1'b1;
      if (flag) seen = 1'b1;
    end
    @(negedge bus_clk);
    clr = 1'b0;
    check("R7", "copy wins over simultaneous clear", seen, 1);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_cadence();
    t_flag();
    t_lowpower_bypass();
    t_wake();
    t_clr_vs_copy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule